// File: doc/BRIEF.md
# Space-Tagged Posted Write Queue

This block is a second-level posted write queue inside a memory controller. Each write that the upstream side offers carries an address, a data word and byte enables. Together with these the queue receives the live level of the processor's management-mode active signal. When a write is accepted, the queue samples that level and stores it with the entry as a one-bit space tag.

Entries leave the queue strictly in arrival order over a valid/ready downstream port. Each one presents a space-select bit, which tells the memory controller whether to send the write to normal memory or to the management RAM. The bit is always the tag stored with the entry, never the current level of the active signal. This matters when the processor enters management mode while older writes are still queued. Those older writes still reach normal memory, and writes accepted during management mode go to the management space.

The empty flag lets the controller see when every write queued before a mode change has been retired. The full flag shows that the upstream side is being stalled.

Top module: `smm_wbuf`

## Requirements
- R1: While reset is held and directly after it, `empty` is 1, `full` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: A write is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. When that write reaches the head, `out_smram` equals the level of `smm_active` at that edge (1 = management space, 0 = normal memory).
- R3: An entry's `out_smram` does not depend on the level of `smm_active` while the entry is queued or draining. Writes queued before `smm_active` rises still drain with `out_smram` = 0, and writes queued during it still drain with 1 after it falls.
- R4: Entries are presented on `out_addr`, `out_data`, `out_be` in exactly the order they were accepted, whatever their tags.
- R5: When `DEPTH` entries are queued, `in_ready` is 0. A write offered then is not taken; it is accepted unchanged once an entry drains and the offer is still held.
- R6: An accept and a drain in the same cycle leave the number of queued entries unchanged. No entry is lost or duplicated.
- R7: `empty` is 1 exactly when no entry is queued, and `out_valid` equals the inverse of `empty`.
- R8: `full` is 1 exactly when `DEPTH` entries are queued.
- R9: While `out_valid` is 1 and `out_ready` is 0, the head entry's outputs stay unchanged on the next cycle and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream write offered |
| in_ready | output | 1 | Queue can take a write |
| in_addr | input | 32 | Write address |
| in_data | input | 32 | Write data |
| in_be | input | 4 | Byte enables |
| smm_active | input | 1 | Live management-mode active level |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Downstream takes head entry |
| out_addr | output | 32 | Head entry address |
| out_data | output | 32 | Head entry data |
| out_be | output | 4 | Head entry byte enables |
| out_smram | output | 1 | Head entry space select, 1 = management RAM |
| empty | output | 1 | No entries queued |
| full | output | 1 | All entries occupied |

## Verification
The bench builds the queue with `DEPTH` = 3. With this depth the pointers wrap at a value that is not a power of two, and the full state is reached in three writes. That small depth makes the structured sweep practical. At every fill level from empty to full, the sweep applies all eight combinations of offer, live mode level and downstream ready. Directed sequences then raise and lower the mode level across queued entries, and a pseudo-random run then mixes accepts, drains and mode changes over several hundred cycles.

// File: rtl/smm_wbuf_pkg.sv
package smm_wbuf_pkg;

    localparam int WB_ADDR_W = 32;
    localparam int WB_DATA_W = 32;
    localparam int WB_BE_W   = WB_DATA_W / 8;

    typedef enum logic {
        SPACE_NORMAL = 1'b0,
        SPACE_SMRAM  = 1'b1
    } wb_space_e;

    typedef struct packed {
        logic [WB_ADDR_W-1:0] addr;
        logic [WB_DATA_W-1:0] data;
        logic [WB_BE_W-1:0]   be;
        wb_space_e            space;
    } wb_entry_t;

endpackage

// File: rtl/smm_wbuf_ctrl.sv
module smm_wbuf_ctrl #(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic             full,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (st_q.cnt == CNT_W'(DEPTH));
    assign empty  = (st_q.cnt == '0);
    assign push   = push_req && !full;
    assign pop    = pop_req && !empty;
    assign wr_idx = st_q.wr;
    assign rd_idx = st_q.rd;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full); // R5
    AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(full) && $stable(empty)); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R7
    AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(1)) && pop && !push |=> empty); // R7

endmodule

// File: rtl/smm_wbuf_store.sv
module smm_wbuf_store
    import smm_wbuf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  wb_entry_t        wr_entry,
    input  logic [PTR_W-1:0] rd_idx,
    output wb_entry_t        rd_entry
);

    wb_entry_t slot_d [DEPTH];
    wb_entry_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_comb begin
            slot_d[i] = slot_q[i];
            if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot_d[i] = wr_entry;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign rd_entry = slot_q[rd_idx];

endmodule

// File: rtl/smm_wbuf.sv
module smm_wbuf
    import smm_wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WB_ADDR_W-1:0] in_addr,
    input  logic [WB_DATA_W-1:0] in_data,
    input  logic [WB_BE_W-1:0]   in_be,
    input  logic                 smm_active,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WB_ADDR_W-1:0] out_addr,
    output logic [WB_DATA_W-1:0] out_data,
    output logic [WB_BE_W-1:0]   out_be,
    output logic                 out_smram,
    output logic                 empty,
    output logic                 full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             push, pop;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    wb_entry_t        new_entry, head_entry;

    always_comb begin
        new_entry.addr  = in_addr;
        new_entry.data  = in_data;
        new_entry.be    = in_be;
        new_entry.space = smm_active ? SPACE_SMRAM : SPACE_NORMAL;
    end

    smm_wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (in_valid),
        .pop_req  (out_ready),
        .push     (push),
        .pop      (pop),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .full     (full),
        .empty    (empty)
    );

    smm_wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_idx   (wr_idx),
        .wr_entry (new_entry),
        .rd_idx   (rd_idx),
        .rd_entry (head_entry)
    );

    assign in_ready  = !full;
    assign out_valid = !empty;
    assign out_addr  = head_entry.addr;
    assign out_data  = head_entry.data;
    assign out_be    = head_entry.be;
    assign out_smram = (head_entry.space == SPACE_SMRAM);

    AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        empty && in_valid && in_ready |=> out_valid && (out_smram == $past(smm_active))); // R2
    AST_HEAD_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        empty && in_valid && in_ready |=> out_addr == $past(in_addr)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
            && $stable(out_be) && $stable(out_smram)); // R9
    AST_TAG_IGNORES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && $changed(smm_active) |=> $stable(out_smram)); // R3

endmodule

// File: tb/smm_wbuf_bench.sv
module smm_wbuf_bench;

    localparam int CLK_P = 10;
    localparam int D     = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, smm_active;
    logic [31:0] in_addr, in_data;
    logic [3:0]  in_be;
    logic        out_valid, out_ready, out_smram, empty, full;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_be;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [31:0] q_addr [D];
    logic [31:0] q_data [D];
    logic [3:0]  q_be   [D];
    logic        q_tag  [D];
    int          cnt = 0;
    int          k   = 0;
    bit          was_held = 0;
    bit          was_both = 0;

    always #(CLK_P/2) clk = ~clk;

    smm_wbuf #(.DEPTH(D)) u_smm_wbuf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
        .smm_active(smm_active),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_data(out_data), .out_be(out_be),
        .out_smram(out_smram), .empty(empty), .full(full)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit iv, input bit sm, input bit ordy);
        bit acc, pop;
        @(negedge clk);
        in_valid   = iv;
        smm_active = sm;
        out_ready  = ordy;
        in_addr    = 32'h1000_0000 + 32'(k) * 4;
        in_data    = (32'(k) * 32'h0101_0101) ^ 32'hA5C3_5A3C;
        in_be      = 4'(k * 7 + 1);
        #1;
        chk(in_ready == (cnt < D), "R5", 32'(in_ready), 32'(cnt < D));
        chk(full == (cnt == D), was_both ? "R6" : "R8", 32'(full), 32'(cnt == D));
        chk(empty == (cnt == 0), was_both ? "R6" : "R7", 32'(empty), 32'(cnt == 0));
        chk(out_valid == (cnt != 0), "R7", 32'(out_valid), 32'(cnt != 0));
        if (cnt > 0) begin
            chk(out_addr == q_addr[0], was_held ? "R9" : "R4", out_addr, q_addr[0]);
            chk(out_data == q_data[0], "R4", out_data, q_data[0]);
            chk(out_be == q_be[0], "R4", 32'(out_be), 32'(q_be[0]));
            chk(out_smram == q_tag[0], (sm != q_tag[0]) ? "R3" : "R2",
                32'(out_smram), 32'(q_tag[0]));
        end
        acc = iv && (cnt < D);
        pop = ordy && (cnt > 0);
        was_held = (cnt > 0) && !ordy;
        was_both = acc && pop;
        @(posedge clk);
        if (pop) begin
            for (int i = 0; i < D - 1; i++) begin
                q_addr[i] = q_addr[i+1];
                q_data[i] = q_data[i+1];
                q_be[i]   = q_be[i+1];
                q_tag[i]  = q_tag[i+1];
            end
            cnt--;
        end
        if (acc) begin
            q_addr[cnt] = in_addr;
            q_data[cnt] = in_data;
            q_be[cnt]   = in_be;
            q_tag[cnt]  = sm;
            cnt++;
            k++;
        end
    endtask

    task automatic drain_all(input bit sm);
        while (cnt > 0) step(1'b0, sm, 1'b1);
    endtask

    task automatic fill_to(input int lvl, input bit sm);
        while (cnt < lvl) step(1'b1, sm, 1'b0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lcg;
        rst_n = 1'b0; in_valid = 1'b0; smm_active = 1'b0; out_ready = 1'b0;
        in_addr = '0; in_data = '0; in_be = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(empty == 1'b1, "R1", 32'(empty), 1);
        chk(full == 1'b0, "R1", 32'(full), 0);
        chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", 32'(in_ready), 1);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);

        // R3: normal-mode writes queued, then mode rises, stall while full (R5)
        fill_to(D, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        drain_all(1'b1);

        // R3: management-mode writes drain after mode falls
        fill_to(D, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        drain_all(1'b0);

        // R6: structured sweep over fill level and input combination
        for (int lvl = 0; lvl <= D; lvl++) begin
            for (int c = 0; c < 8; c++) begin
                drain_all(1'b0);
                fill_to(lvl, c[1]);
                step(c[0], c[1], c[2]);
                step(1'b0, ~c[1], 1'b0);
            end
        end
        drain_all(1'b0);

        lcg = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            lcg = lcg * 1103515245 + 12345;
            step(lcg[16], lcg[25] & lcg[26] ? ~smm_active : smm_active, lcg[18] | lcg[20]);
        end
        drain_all(1'b0);
        step(1'b0, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule